// File: doc/BRIEF.md
# Cache Line Write-Cycle Coherency Controller

This block owns the coherency state of a single cache line and decides what happens when the processor writes to that line. The line holds a four-state MESI code and a read-only tag bit. Each write arrives with a set of attributes. The processor side supplies lock, page write-through and page cache-disable. The memory side supplies write-through, cacheable enable, read-only and a force-to-modified request.

From the present state and these attributes the block decides four things. It decides whether the data SRAM is written and whether a write-through cycle must go out on the memory bus. It decides the state the line moves to and whether a line-fill allocation follows a write miss. It also drives a hint back to the processor that tells it whether the line may be treated as write-back.

A write-through cycle is raised as a level request and held until the memory bus reports completion. The state change is committed on that completion. An allocation is raised the same way after the write-through finishes. Its final state is held in the block until the fill reports done. No new write is accepted while either request is outstanding.

Top module: `wr_coh_ctrl`

## Requirements
- R1: With the line Modified (code 2'b11), an unlocked write strobes the SRAM, raises no memory-bus request and leaves the line Modified. A locked write strobes the SRAM, raises a write-through and leaves the line Modified.
- R2: With the line Exclusive (code 2'b10), an unlocked write strobes the SRAM with no write-through and moves the line to Modified. A locked write strobes the SRAM, raises a write-through and leaves the line Exclusive.
- R3: With the line Shared (code 2'b01) and the read-only bit set, a write raises a write-through, does not strobe the SRAM and leaves the line Shared with read-only still set.
- R4: With the line Shared and read-only clear, a write that has page write-through, memory write-through or lock raises a write-through, strobes the SRAM and leaves the line Shared.
- R5: With the line Shared and read-only clear, a write that has none of page write-through, memory write-through or lock raises a write-through and strobes the SRAM. The line then moves to Exclusive, or to Modified when force-to-modified is set.
- R6: With the line Invalid (code 2'b00), a write that has page cache-disable, cacheable enable low, page write-through or lock raises a write-through only. The SRAM is not strobed, no allocation follows and the line stays Invalid.
- R7: With the line Invalid, a cacheable, unlocked write with no page write-through raises a write-through and, after it completes, an allocation request. When the fill completes the line becomes Shared if memory read-only is set, with the read-only bit set and the other attributes ignored. Otherwise it becomes Shared if memory write-through is set, else Modified if force-to-modified is set, else Exclusive, and read-only is clear.
- R8: `wb_hint` is high exactly when the stored line state is Modified or Exclusive.
- R9: A write is accepted when `wr_valid` is high while `wr_ready` is high. `sram_wr` pulses in the cycle after acceptance and `mem_wr_req` rises in that same cycle. A state without a write-through is committed on the accepting edge. Otherwise the state is committed on the edge where `mem_wr_done` is seen high, and for an allocation on the edge where `alloc_done` is seen high.
- R10: `wr_ready` is low while a memory-bus request or an allocation is outstanding, and `wr_valid` has no effect then.
- R11: After reset the line is Invalid with read-only clear, `wr_ready` is high and no request or strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Processor write request |
| wr_lock | input | 1 | Write is part of a locked sequence |
| wr_pwt | input | 1 | Page write-through attribute |
| wr_pcd | input | 1 | Page cache-disable attribute |
| mem_wt | input | 1 | Memory-side write-through attribute |
| mem_ken | input | 1 | Memory-side cacheable enable |
| mem_ro | input | 1 | Memory-side read-only attribute |
| mem_force_m | input | 1 | Request that the line end in Modified |
| mem_wr_done | input | 1 | Memory-bus write-through completed |
| alloc_done | input | 1 | Line fill completed |
| wr_ready | output | 1 | Block can accept a write |
| sram_wr | output | 1 | Data SRAM write strobe |
| mem_wr_req | output | 1 | Write-through cycle outstanding on memory bus |
| alloc_req | output | 1 | Line-fill allocation outstanding |
| wb_hint | output | 1 | High: processor may treat line as write-back |
| line_state | output | 2 | Stored MESI code: 00 I, 01 S, 10 E, 11 M |
| line_ro | output | 1 | Stored read-only tag bit |

## Verification
The SRAM strobe and the rise of the memory-bus request both appear in the first cycle after the accepting edge. A state change that needs no write-through is visible in that same cycle. A state change behind a write-through shows in the cycle after `mem_wr_done` is sampled, and an allocated state shows in the cycle after `alloc_done` is sampled. The bench drives inputs and compares outputs on the falling edge, against a model that is advanced on the rising edge. Every cycle's comparison therefore sees exactly the registers updated by the preceding edge. Completion latencies are varied, and `wr_valid` is pulsed during outstanding requests to show it is ignored.

// File: rtl/wcc_pkg.sv
// Shared types for the write-cycle coherency controller.
// Assumes a single line; state codes are visible on the top ports.
package wcc_pkg;

    localparam int ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } mesi_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'b00,
        PH_MEM   = 2'b01,
        PH_ALLOC = 2'b10
    } phase_t;

    typedef struct packed {
        logic lock;
        logic pwt;
        logic pcd;
        logic mem_wt;
        logic ken;
        logic mem_ro;
        logic force_m;
    } wattr_t;

    typedef struct packed {
        mesi_t nxt;
        logic  nxt_ro;
        logic  wthru;
        logic  sram_upd;
        logic  alloc;
        mesi_t alloc_st;
        logic  alloc_ro;
    } wplan_t;

endpackage

// File: rtl/wcc_decode.sv
// Purely combinational decision for one write: from the stored state,
// read-only bit and the write attributes it produces the next state,
// the SRAM/write-through actions and any allocation outcome.
// Assumes it is only consulted when a write is being accepted.
module wcc_decode
    import wcc_pkg::*;
(
    input  mesi_t  cur_st,
    input  logic   cur_ro,
    input  wattr_t attr,
    output wplan_t plan
);

    logic no_alloc;
    logic s_plain;

    // Conditions that block allocation and that keep a shared line shared.
    always_comb begin
        no_alloc = attr.pcd | ~attr.ken | attr.pwt | attr.lock;
        s_plain  = ~(attr.pwt | attr.mem_wt | attr.lock);
    end

    // Per-state decision table.
    always_comb begin
        plan          = '0;
        plan.nxt      = cur_st;
        plan.nxt_ro   = cur_ro;
        plan.alloc_st = ST_I;
        unique case (cur_st)
            ST_M: begin
                plan.sram_upd = 1'b1;
                plan.wthru    = attr.lock;
            end
            ST_E: begin
                plan.sram_upd = 1'b1;
                plan.wthru    = attr.lock;
                plan.nxt      = attr.lock ? ST_E : ST_M;
            end
            ST_S: begin
                plan.wthru    = 1'b1;
                plan.sram_upd = ~cur_ro;
                if (!cur_ro && s_plain)
                    plan.nxt = attr.force_m ? ST_M : ST_E;
            end
            default: begin
                plan.wthru = 1'b1;
                plan.alloc = ~no_alloc;
                if (attr.mem_ro) begin
                    plan.alloc_st = ST_S;
                    plan.alloc_ro = 1'b1;
                end else if (attr.mem_wt) begin
                    plan.alloc_st = ST_S;
                end else begin
                    plan.alloc_st = attr.force_m ? ST_M : ST_E;
                end
            end
        endcase
    end

endmodule

// File: rtl/wcc_seq.sv
// Sequencer: accepts a write, holds its plan while the memory-bus
// write-through and any allocation are outstanding, and emits the
// commit strobe for the line register. Assumes done inputs are only
// meaningful while the matching request is high.
module wcc_seq
    import wcc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_valid,
    input  wplan_t plan,
    input  logic   mem_wr_done,
    input  logic   alloc_done,
    output logic   wr_ready,
    output logic   sram_wr,
    output logic   mem_wr_req,
    output logic   alloc_req,
    output logic   commit_en,
    output mesi_t  commit_st,
    output logic   commit_ro
);

    phase_t ph_q;
    wplan_t held_q;
    logic   sram_q;
    logic   accept;

    assign wr_ready   = (ph_q == PH_IDLE);
    assign accept     = wr_valid && wr_ready;
    assign mem_wr_req = (ph_q == PH_MEM);
    assign alloc_req  = (ph_q == PH_ALLOC);
    assign sram_wr    = sram_q;

    // Select what is written into the line register this cycle.
    always_comb begin
        commit_en = 1'b0;
        commit_st = ST_I;
        commit_ro = 1'b0;
        unique case (ph_q)
            PH_IDLE: if (accept && !plan.wthru) begin
                commit_en = 1'b1;
                commit_st = plan.nxt;
                commit_ro = plan.nxt_ro;
            end
            PH_MEM: if (mem_wr_done) begin
                commit_en = 1'b1;
                commit_st = held_q.nxt;
                commit_ro = held_q.nxt_ro;
            end
            PH_ALLOC: if (alloc_done) begin
                commit_en = 1'b1;
                commit_st = held_q.alloc_st;
                commit_ro = held_q.alloc_ro;
            end
            default: ;
        endcase
    end

    // Phase, held plan and SRAM strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q   <= PH_IDLE;
            held_q <= '0;
            sram_q <= 1'b0;
        end else begin
            sram_q <= accept && plan.sram_upd;
            unique case (ph_q)
                PH_IDLE: if (accept && plan.wthru) begin
                    ph_q   <= PH_MEM;
                    held_q <= plan;
                end
                PH_MEM: if (mem_wr_done)
                    ph_q <= held_q.alloc ? PH_ALLOC : PH_IDLE;
                PH_ALLOC: if (alloc_done)
                    ph_q <= PH_IDLE;
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wcc_line_reg.sv
// Stored MESI state and read-only tag of the line, plus the
// write-back hint derived from it. Written only on commit.
module wcc_line_reg
    import wcc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  commit_en,
    input  mesi_t commit_st,
    input  logic  commit_ro,
    output mesi_t st,
    output logic  ro,
    output logic  wb_hint
);

    // Line state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_I;
            ro <= 1'b0;
        end else if (commit_en) begin
            st <= commit_st;
            ro <= commit_ro;
        end
    end

    // Write-back permitted only for owned lines.
    always_comb wb_hint = (st == ST_M) || (st == ST_E);

endmodule

// File: rtl/wr_coh_ctrl.sv
// Top of the write-cycle coherency controller for one cache line.
// Packs the attribute pins, decodes the write against the stored
// state and sequences write-through and allocation handshakes.
module wr_coh_ctrl
    import wcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic       wr_lock,
    input  logic       wr_pwt,
    input  logic       wr_pcd,
    input  logic       mem_wt,
    input  logic       mem_ken,
    input  logic       mem_ro,
    input  logic       mem_force_m,
    input  logic       mem_wr_done,
    input  logic       alloc_done,
    output logic       wr_ready,
    output logic       sram_wr,
    output logic       mem_wr_req,
    output logic       alloc_req,
    output logic       wb_hint,
    output logic [1:0] line_state,
    output logic       line_ro
);

    wattr_t attr;
    wplan_t plan;
    mesi_t  st;
    logic   ro;
    logic   commit_en;
    mesi_t  commit_st;
    logic   commit_ro;

    // Gather the attribute pins into one bundle.
    always_comb begin
        attr.lock    = wr_lock;
        attr.pwt     = wr_pwt;
        attr.pcd     = wr_pcd;
        attr.mem_wt  = mem_wt;
        attr.ken     = mem_ken;
        attr.mem_ro  = mem_ro;
        attr.force_m = mem_force_m;
    end

    wcc_decode u_dec (
        .cur_st (st),
        .cur_ro (ro),
        .attr   (attr),
        .plan   (plan)
    );

    wcc_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    (wr_valid),
        .plan        (plan),
        .mem_wr_done (mem_wr_done),
        .alloc_done  (alloc_done),
        .wr_ready    (wr_ready),
        .sram_wr     (sram_wr),
        .mem_wr_req  (mem_wr_req),
        .alloc_req   (alloc_req),
        .commit_en   (commit_en),
        .commit_st   (commit_st),
        .commit_ro   (commit_ro)
    );

    wcc_line_reg u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_en (commit_en),
        .commit_st (commit_st),
        .commit_ro (commit_ro),
        .st        (st),
        .ro        (ro),
        .wb_hint   (wb_hint)
    );

    assign line_state = st;
    assign line_ro    = ro;

endmodule

// File: rtl/wcc_checker.sv
// Port-level properties of the write-cycle coherency controller,
// bound to every instance of the top module.
module wcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       wr_lock,
    input logic       wr_ready,
    input logic       sram_wr,
    input logic       mem_wr_req,
    input logic       alloc_req,
    input logic       mem_wr_done,
    input logic       alloc_done,
    input logic [1:0] line_state,
    input logic       line_ro
);

    logic acc;
    assign acc = wr_valid && wr_ready;

    // R10: never both requests at once
    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_req && alloc_req));

    // R10: no acceptance while anything is outstanding
    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req || alloc_req) |-> !wr_ready);

    // R1: unlocked write to a modified line stays local
    p_m_local_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && line_state == 2'b11 && !wr_lock) |=>
        (line_state == 2'b11 && sram_wr && !mem_wr_req));

    // R2: locked write to an exclusive line goes through and stays exclusive
    p_e_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && line_state == 2'b10 && wr_lock) |=>
        (mem_wr_req && sram_wr && line_state == 2'b10));

    // R3: read-only shared line is not written in the SRAM
    p_s_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && line_state == 2'b01 && line_ro) |=> (mem_wr_req && !sram_wr));

    // R6: a miss never writes the SRAM
    p_i_nosram_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && line_state == 2'b00) |=> (mem_wr_req && !sram_wr));

    // R9: state frozen until the memory-bus write completes
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_req && !mem_wr_done) |=> $stable(line_state));

    // R7: allocation completion frees the block
    p_alloc_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && alloc_done) |=> (!alloc_req && wr_ready));

endmodule

bind wr_coh_ctrl wcc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_lock     (wr_lock),
    .wr_ready    (wr_ready),
    .sram_wr     (sram_wr),
    .mem_wr_req  (mem_wr_req),
    .alloc_req   (alloc_req),
    .mem_wr_done (mem_wr_done),
    .alloc_done  (alloc_done),
    .line_state  (line_state),
    .line_ro     (line_ro)
);

// File: tb/tb_wr_coh_ctrl.sv
// Bench: behavioural reference model advanced on the rising edge,
// compared against the design on every falling edge.
module tb_wr_coh_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 0, wr_lock = 0, wr_pwt = 0, wr_pcd = 0;
    logic mem_wt = 0, mem_ken = 0, mem_ro = 0, mem_force_m = 0;
    logic mem_wr_done = 0, alloc_done = 0;
    logic wr_ready, sram_wr, mem_wr_req, alloc_req, wb_hint, line_ro;
    logic [1:0] line_state;

    always #4 clk = ~clk;   // 125 MHz

    wr_coh_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_lock(wr_lock),
        .wr_pwt(wr_pwt), .wr_pcd(wr_pcd), .mem_wt(mem_wt), .mem_ken(mem_ken),
        .mem_ro(mem_ro), .mem_force_m(mem_force_m), .mem_wr_done(mem_wr_done),
        .alloc_done(alloc_done), .wr_ready(wr_ready), .sram_wr(sram_wr),
        .mem_wr_req(mem_wr_req), .alloc_req(alloc_req), .wb_hint(wb_hint),
        .line_state(line_state), .line_ro(line_ro)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    int m_st = 0, m_ph = 0;
    bit m_ro = 0, m_sram = 0;
    int p_nx = 0, p_ast = 0;
    bit p_ro = 0, p_alloc = 0, p_aro = 0;
    string m_tag = "R11";

    // Reference model: MESI codes 0 I, 1 S, 2 E, 3 M; phase 0 idle, 1 memory, 2 fill.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_ro = 0; m_ph = 0; m_sram = 0; m_tag = "R11";
        end else begin
            m_sram = 0;
            if (m_ph == 0 && wr_valid) begin
                bit wt, upd; int nx;
                wt = 1; upd = 1; nx = m_st; p_alloc = 0; p_ro = m_ro;
                if (m_st == 3) begin
                    m_tag = "R1"; wt = wr_lock;
                end else if (m_st == 2) begin
                    m_tag = "R2"; wt = wr_lock; nx = wr_lock ? 2 : 3;
                end else if (m_st == 1 && m_ro) begin
                    m_tag = "R3"; upd = 0;
                end else if (m_st == 1 && (wr_pwt || mem_wt || wr_lock)) begin
                    m_tag = "R4";
                end else if (m_st == 1) begin
                    m_tag = "R5"; nx = mem_force_m ? 3 : 2;
                end else begin
                    upd = 0;
                    if (wr_pcd || !mem_ken || wr_pwt || wr_lock) m_tag = "R6";
                    else begin
                        m_tag = "R7"; p_alloc = 1; p_aro = mem_ro;
                        if (mem_ro || mem_wt) p_ast = 1;
                        else p_ast = mem_force_m ? 3 : 2;
                    end
                end
                m_sram = upd;
                if (wt) begin m_ph = 1; p_nx = nx; end
                else m_st = nx;
            end else if (m_ph == 1 && mem_wr_done) begin
                m_st = p_nx; m_ro = p_ro; m_ph = p_alloc ? 2 : 0;
            end else if (m_ph == 2 && alloc_done) begin
                m_st = p_ast; m_ro = p_aro; m_ph = 0;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        bit bad; bit e_rdy, e_mreq, e_areq, e_hint;
        e_rdy = (m_ph == 0); e_mreq = (m_ph == 1); e_areq = (m_ph == 2);
        e_hint = (m_st >= 2);
        bad = 0;
        n_chk++;
        if (line_state != m_st[1:0]) begin bad = 1;
            $display("FAIL %s line_state act=%0d exp=%0d", m_tag, line_state, m_st); end
        if (line_ro != m_ro) begin bad = 1;
            $display("FAIL %s line_ro act=%0b exp=%0b", m_tag, line_ro, m_ro); end
        if (sram_wr != m_sram) begin bad = 1;
            $display("FAIL %s sram_wr act=%0b exp=%0b", m_tag, sram_wr, m_sram); end
        if (mem_wr_req != e_mreq) begin bad = 1;
            $display("FAIL R9 mem_wr_req act=%0b exp=%0b (%s)", mem_wr_req, e_mreq, m_tag); end
        if (alloc_req != e_areq) begin bad = 1;
            $display("FAIL R7 alloc_req act=%0b exp=%0b", alloc_req, e_areq); end
        if (wr_ready != e_rdy) begin bad = 1;
            $display("FAIL R10 wr_ready act=%0b exp=%0b", wr_ready, e_rdy); end
        if (wb_hint != e_hint) begin bad = 1;
            $display("FAIL R8 wb_hint act=%0b exp=%0b", wb_hint, e_hint); end
        if (bad) n_bad++;
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp<=20000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);   // R11 reset state compared here
        rst_n = 1;
    endtask

    // One write with attributes {lock,pwt,pcd,mwt,ken,mro,fm}; latencies for
    // completion; poke pulses wr_valid while busy (R10).
    task automatic do_wr(input bit lk, pw, pc, mw, kn, mr, fm,
                         input int mlat, input int alat, input bit poke);
        @(negedge clk);
        wr_valid = 1; wr_lock = lk; wr_pwt = pw; wr_pcd = pc;
        mem_wt = mw; mem_ken = kn; mem_ro = mr; mem_force_m = fm;
        @(negedge clk);
        wr_valid = 0;
        if (mem_wr_req) begin
            for (int i = 0; i < mlat; i++) begin wr_valid = poke; @(negedge clk); end
            wr_valid = 0; mem_wr_done = 1;
            @(negedge clk);
            mem_wr_done = 0;
        end
        if (alloc_req) begin
            for (int i = 0; i < alat; i++) begin wr_valid = poke; @(negedge clk); end
            wr_valid = 0; alloc_done = 1;
            @(negedge clk);
            alloc_done = 0;
        end
        {wr_lock, wr_pwt, wr_pcd, mem_wt, mem_ken, mem_ro, mem_force_m} = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R6: uncacheable and non-allocating misses stay Invalid
        do_wr(0,0,1,0,1,0,0, 1,0,0);
        do_wr(0,0,0,0,0,0,0, 0,0,0);
        do_wr(1,0,0,0,1,0,0, 2,0,1);
        do_wr(0,1,0,0,1,0,0, 0,0,0);
        // R7 plain allocation to Exclusive, then R2 and R1 on the owned line
        do_wr(0,0,0,0,1,0,0, 2,3,1);
        do_wr(1,0,0,0,0,0,0, 1,0,1);
        do_wr(0,0,0,0,0,0,0, 0,0,0);
        do_wr(0,0,0,0,0,0,0, 0,0,0);
        do_wr(1,0,0,0,0,0,0, 3,0,1);
        // R7 memory write-through allocation to Shared, then R4 and R5
        do_reset();
        do_wr(0,0,0,1,1,0,0, 0,0,0);
        do_wr(0,1,0,0,0,0,0, 1,0,0);
        do_wr(1,0,0,0,0,0,0, 0,0,0);
        do_wr(0,0,0,1,0,0,1, 2,0,1);
        do_wr(0,0,0,0,0,0,0, 1,0,0);
        // R7 forced-modified allocation
        do_reset();
        do_wr(0,0,0,0,1,0,1, 1,1,0);
        // R5 forced to Modified from Shared
        do_reset();
        do_wr(0,0,0,1,1,0,1, 0,2,0);
        do_wr(0,0,0,0,0,0,1, 0,0,0);
        // R7 memory read-only overrides the rest; R3 on the read-only line
        do_reset();
        do_wr(0,0,0,1,1,1,1, 1,4,1);
        do_wr(0,0,0,0,0,0,0, 1,0,0);
        do_wr(0,1,0,0,0,0,1, 0,0,1);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule